// File: doc/BRIEF.md
# Mailbox interrupt controller for a two-port shared memory

This block watches the access traffic of both ports of a shared memory and gives each port an active-low interrupt flag for passing messages. The two highest word addresses are set aside as mailboxes. The all-ones address is the mailbox of the right port, and the address one below it is the mailbox of the left port. When a port writes into the other port's mailbox, the owner's interrupt goes low. The interrupt stays low until the owner reads its own mailbox.

Each port presents an enable, a write strobe, a read strobe, a word address and a busy input from the contention arbiter. An active busy disables both mailbox effects for that port. A busy port cannot raise the other port's interrupt, and it cannot clear its own. The memory array, the message data and the arbiter sit outside the block. The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is held and after reset is released, `lt_irq_n` and `rt_irq_n` are both 1 (deasserted) until a mailbox event occurs.
- R2: An enabled left write (`lt_en`=1, `lt_wr`=1, `lt_busy`=0) to address all-ones drives `rt_irq_n` to 0 one clock later. An enabled right write to address all-ones minus one drives `lt_irq_n` to 0 one clock later.
- R3: An enabled read with busy at 0 and the write strobe at 0, made by a port to its own mailbox, drives that port's interrupt to 1 one clock later. For the right port the mailbox is all-ones. For the left port it is all-ones minus one.
- R4: A read of the other port's mailbox leaves both interrupts unchanged.
- R5: A mailbox write made while the writing port's busy is 1 does not change the other port's interrupt.
- R6: A read of a port's own mailbox made while that port's busy is 1 does not clear its interrupt.
- R7: When a set and a clear of the same interrupt occur in the same cycle, the interrupt is 0 one clock later.
- R8: The following accesses change neither interrupt: any access with the enable at 0, and any access to a non-mailbox address. An access with both strobes at 1 acts only as a write.
- R9: Both mailbox addresses follow from `ADDR_W`: the right mailbox is 2**ADDR_W-1 and the left mailbox is 2**ADDR_W-2. An `ADDR_W` outside 2..31 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_en | input | 1 | Left port access enable |
| lt_wr | input | 1 | Left port write strobe |
| lt_rd | input | 1 | Left port read strobe |
| lt_addr | input | ADDR_W | Left port word address |
| lt_busy | input | 1 | Left port busy from the arbiter, active high |
| rt_en | input | 1 | Right port access enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_rd | input | 1 | Right port read strobe |
| rt_addr | input | ADDR_W | Right port word address |
| rt_busy | input | 1 | Right port busy from the arbiter, active high |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The block holds two flag bits, and each bit is driven directly to a port. A wrong internal state therefore shows on the interrupt pin at the first sampling point after the faulty clock edge. The error persists until the next legitimate set or clear overwrites it. A decoder that matches the wrong address, or that ignores busy, produces a wrong pin level one cycle after the offending access. For this reason the bench sweeps every address, every strobe mix, and every enable and busy level on each port, and it does so from all four flag states.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum int {
      SIDE_LEFT  = 0,
      SIDE_RIGHT = 1
   } side_e;

   // Mailbox word for a side: right owns the top word, left the one below.
   function automatic logic [31:0] box_addr(input int aw, input side_e s);
      logic [31:0] top;
      top = (32'd1 << aw) - 32'd1;
      return (s == SIDE_RIGHT) ? top : top - 32'd1;
   endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
   parameter int                ADDR_W  = 14,
   parameter logic [ADDR_W-1:0] OWN_BOX = '1,
   parameter logic [ADDR_W-1:0] OTH_BOX = '0
) (
   input  logic              en,
   input  logic              wr,
   input  logic              rd,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output logic              own_rd,
   output logic              oth_wr
);
   logic granted;
   logic hit_own;
   logic hit_oth;

   always_comb begin
      granted = en & ~busy;
      hit_own = (addr == OWN_BOX);
      hit_oth = (addr == OTH_BOX);
      // both strobes together count as a write only
      own_rd  = granted & rd & ~wr & hit_own;
      oth_wr  = granted & wr & hit_oth;
   end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   always_ff @(posedge clk) begin
      if (!rst_n)   irq_n <= 1'b1;
      else if (set) irq_n <= 1'b0;
      else if (clr) irq_n <= 1'b1;
   end
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_en,
   input  logic              lt_wr,
   input  logic              lt_rd,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_busy,
   input  logic              rt_en,
   input  logic              rt_wr,
   input  logic              rt_rd,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_busy,
   output logic              lt_irq_n,
   output logic              rt_irq_n
);
   localparam int NSIDE = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
         $error("mbox_irq_ctrl: ADDR_W must lie in 2..31");
      end
   endgenerate

   logic [NSIDE-1:0]  en_v, wr_v, rd_v, busy_v;
   logic [ADDR_W-1:0] addr_v [NSIDE];
   logic [NSIDE-1:0]  own_rd_v, oth_wr_v, irq_n_v;

   always_comb begin
      en_v   = {rt_en,   lt_en};
      wr_v   = {rt_wr,   lt_wr};
      rd_v   = {rt_rd,   lt_rd};
      busy_v = {rt_busy, lt_busy};
      addr_v[SIDE_LEFT]  = lt_addr;
      addr_v[SIDE_RIGHT] = rt_addr;
   end

   generate
      for (genvar g = 0; g < NSIDE; g++) begin : g_side
         localparam logic [ADDR_W-1:0] OWN =
            ADDR_W'(box_addr(ADDR_W, side_e'(g)));
         localparam logic [ADDR_W-1:0] OTH =
            ADDR_W'(box_addr(ADDR_W, side_e'(NSIDE-1-g)));

         mbox_port_decode #(
            .ADDR_W (ADDR_W),
            .OWN_BOX(OWN),
            .OTH_BOX(OTH)
         ) u_dec (
            .en    (en_v[g]),
            .wr    (wr_v[g]),
            .rd    (rd_v[g]),
            .busy  (busy_v[g]),
            .addr  (addr_v[g]),
            .own_rd(own_rd_v[g]),
            .oth_wr(oth_wr_v[g])
         );

         // flag g is raised by the opposite side, lowered by its owner
         mbox_irq_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (oth_wr_v[NSIDE-1-g]),
            .clr  (own_rd_v[g]),
            .irq_n(irq_n_v[g])
         );
      end
   endgenerate

   assign lt_irq_n = irq_n_v[SIDE_LEFT];
   assign rt_irq_n = irq_n_v[SIDE_RIGHT];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lt_en,
   input logic              lt_wr,
   input logic              lt_rd,
   input logic [ADDR_W-1:0] lt_addr,
   input logic              lt_busy,
   input logic              rt_en,
   input logic              rt_wr,
   input logic              rt_rd,
   input logic [ADDR_W-1:0] rt_addr,
   input logic              rt_busy,
   input logic              lt_irq_n,
   input logic              rt_irq_n
);
   localparam logic [ADDR_W-1:0] RBOX = '1;
   localparam logic [ADDR_W-1:0] LBOX = RBOX - 1'b1;

   logic l_set_r, r_set_l, r_clr_r, l_clr_l;
   logic l_wr_blk, r_rd_blk, l_rd_rbox;

   always_comb begin
      l_set_r   = lt_en && lt_wr && !lt_busy && lt_addr == RBOX;
      r_set_l   = rt_en && rt_wr && !rt_busy && rt_addr == LBOX;
      r_clr_r   = rt_en && rt_rd && !rt_wr && !rt_busy && rt_addr == RBOX;
      l_clr_l   = lt_en && lt_rd && !lt_wr && !lt_busy && lt_addr == LBOX;
      l_wr_blk  = lt_en && lt_wr && lt_busy && lt_addr == RBOX;
      r_rd_blk  = rt_en && rt_rd && !rt_wr && rt_busy && rt_addr == RBOX;
      l_rd_rbox = lt_en && lt_rd && !lt_wr && lt_addr == RBOX;
   end

   assert_left_sets_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      l_set_r |=> !rt_irq_n);
   assert_right_sets_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
      r_set_l |=> !lt_irq_n);
   assert_owner_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (r_clr_r && !l_set_r) |=> rt_irq_n);
   assert_left_owner_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (l_clr_l && !r_set_l) |=> lt_irq_n);
   assert_foreign_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd_rbox && !r_clr_r) |=> $stable(rt_irq_n));
   assert_busy_blocks_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (l_wr_blk && !r_clr_r) |=> $stable(rt_irq_n));
   assert_busy_blocks_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rd_blk && !l_set_r) |=> $stable(rt_irq_n));
   assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_set_r && r_clr_r) |=> !rt_irq_n);
   assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_en && !rt_en) |=> ($stable(lt_irq_n) && $stable(rt_irq_n)));
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;
   localparam int AW   = 4;
   localparam int RBOX = (1 << AW) - 1;
   localparam int LBOX = RBOX - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lt_en = 0, lt_wr = 0, lt_rd = 0, lt_busy = 0;
   logic rt_en = 0, rt_wr = 0, rt_rd = 0, rt_busy = 0;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic lt_irq_n, rt_irq_n;

   int n_run = 0;
   int n_fail = 0;
   logic exp_l = 1'b1, exp_r = 1'b1;

   always #5 clk = ~clk;

   mbox_irq_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lt_en(lt_en), .lt_wr(lt_wr), .lt_rd(lt_rd), .lt_addr(lt_addr), .lt_busy(lt_busy),
      .rt_en(rt_en), .rt_wr(rt_wr), .rt_rd(rt_rd), .rt_addr(rt_addr), .rt_busy(rt_busy),
      .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
      end
   endtask

   // Tag for one flag from the access made by its writer (w) and owner (o).
   function automatic string tag_of(input logic set, input logic clr,
                                    input logic wblk, input logic oblk,
                                    input logic frd);
      if (set && clr) return "R7";
      if (set)        return "R2/R9";
      if (clr)        return "R3/R9";
      if (wblk)       return "R5";
      if (oblk)       return "R6";
      if (frd)        return "R4";
      return "R8";
   endfunction

   task automatic step(input logic le, input logic lw, input logic lr, input int la, input logic lb,
                       input logic re, input logic rw, input logic rr, input int ra, input logic rb);
      logic sr, cr, sl, cl;
      string tr, tl;
      lt_en = le; lt_wr = lw; lt_rd = lr; lt_addr = AW'(la); lt_busy = lb;
      rt_en = re; rt_wr = rw; rt_rd = rr; rt_addr = AW'(ra); rt_busy = rb;
      sr = le && lw && !lb && la == RBOX;
      cr = re && rr && !rw && !rb && ra == RBOX;
      sl = re && rw && !rb && ra == LBOX;
      cl = le && lr && !lw && !lb && la == LBOX;
      tr = tag_of(sr, cr, le && lw && lb && la == RBOX, re && rr && !rw && rb && ra == RBOX,
                  le && lr && !lw && la == RBOX);
      tl = tag_of(sl, cl, re && rw && rb && ra == LBOX, le && lr && !lw && lb && la == LBOX,
                  re && rr && !rw && ra == LBOX);
      exp_r = sr ? 1'b0 : (cr ? 1'b1 : exp_r);
      exp_l = sl ? 1'b0 : (cl ? 1'b1 : exp_l);
      @(negedge clk);
      chk(tr, "rt_irq_n", rt_irq_n, exp_r);
      chk(tl, "lt_irq_n", lt_irq_n, exp_l);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "lt_irq_n in reset", lt_irq_n, 1'b1);
      chk("R1", "rt_irq_n in reset", rt_irq_n, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "lt_irq_n after reset", lt_irq_n, 1'b1);
      chk("R1", "rt_irq_n after reset", rt_irq_n, 1'b1);

      for (int s = 0; s < 4; s++) begin
         for (int side = 0; side < 2; side++) begin
            for (int a = 0; a < (1 << AW); a++) begin
               for (int op = 0; op < 3; op++) begin
                  for (int b = 0; b < 2; b++) begin
                     for (int e = 0; e < 2; e++) begin
                        // bring flags to start state s: bit0 left flag, bit1 right flag
                        step(1, 0, 1, LBOX, 0, 1, 0, 1, RBOX, 0);
                        step(s[1], 1, 0, RBOX, 0, s[0], 1, 0, LBOX, 0);
                        if (side == 0)
                           step(e[0], op != 1, op != 0, a, b[0], 0, 0, 0, 0, 0);
                        else
                           step(0, 0, 0, 0, 0, e[0], op != 1, op != 0, a, b[0]);
                     end
                  end
               end
            end
         end
      end

      // same-cycle set and clear on one flag, with every busy mix
      for (int lb = 0; lb < 2; lb++) begin
         for (int rb = 0; rb < 2; rb++) begin
            step(0, 0, 0, 0, 0, 1, 1, 0, LBOX, 0);
            step(1, 1, 0, RBOX, lb[0], 1, 0, 1, RBOX, rb[0]);
            step(1, 0, 1, LBOX, lb[0], 1, 1, 0, LBOX, rb[0]);
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule